// File: doc/BRIEF.md
# Cascadable Up/Down Pointer Counter

A word-wide pointer register built from byte-wide counter slices. Each slice loads from the bus under a write strobe and counts one step per enabled clock, up or down. A carry/borrow chain links each slice to the one above it. A higher slice advances only when every slice below it rolls over. With the defaults, two 8-bit slices form a 16-bit program counter or stack pointer.

A parameter sets the count direction. It can follow the `dir_down_i` input, or it can be fixed to up only or down only, which gives a single-direction counter. A per-slice configuration input forces a slice to read as zero, so a register whose upper half is only 8 bits wide reads back correctly. Reads are combinational and gated by a read strobe. The output is zero when the strobe is low.

Top module: `ptr_cnt`

## Requirements
- R1: While `rst_ni` is low, the stored word is 0x0000. It reads as 0x0000 after reset is released.
- R2: When `wr_en_i` is high at a rising edge, the stored word becomes `data_i` from that edge on.
- R3: When `wr_en_i` and `cnt_en_i` are both high at an edge, the load wins and no count step happens. `chain_o` is low in that cycle.
- R4: With `cnt_en_i` high and the effective direction up, each edge adds one to the word. With `cnt_en_i` low and `wr_en_i` low, the word holds.
- R5: With `cnt_en_i` high and the effective direction down, each edge subtracts one from the word.
- R6: Counting up from a slice value of 0xFF carries into the next slice. For example, 0x00FF steps to 0x0100.
- R7: Counting down from a slice value of 0x00 borrows from the next slice. For example, 0x0100 steps to 0x00FF.
- R8: The word wraps modulo 2^16 in both directions. `chain_o` is high in exactly the cycle in which a count step wraps the top slice: up at 0xFFFF or down at 0x0000.
- R9: `data_o` equals the stored word while `rd_en_i` is high, and it is 0x0000 while `rd_en_i` is low.
- R10: When bit i of `zero_slice_i` is high, bits [8i+7:8i] of `data_o` read as zero. The slice keeps counting and loading underneath, and its value becomes visible again once the bit is cleared.
- R11: With `DIR_MODE` = DIR_DOWN, the counter steps down whatever the level of `dir_down_i`. With DIR_UP, it steps up. With DIR_EXT, `dir_down_i` high means down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 16 | Load value |
| wr_en_i | input | 1 | Load strobe |
| rd_en_i | input | 1 | Read strobe |
| cnt_en_i | input | 1 | Count enable |
| dir_down_i | input | 1 | Direction, 1 = down (used when DIR_MODE = DIR_EXT) |
| zero_slice_i | input | 2 | Per-slice read-as-zero configuration |
| data_o | output | 16 | Read data |
| chain_o | output | 1 | Carry/borrow out of the top slice |

## Verification
The hardest cases to reach are the cascade edges. The low slice has to sit exactly at 0xFF or 0x00 while a count is enabled, and the top slice must also be at its limit to see `chain_o`. The bench reaches them by loading values next to each boundary and then issuing single enabled steps. It also checks that a masked slice keeps counting: it carries into the masked upper half, then clears the mask to expose the result.

// File: rtl/ptr_cnt_pkg.sv
package ptr_cnt_pkg;
  typedef enum logic [1:0] {
    DIR_EXT  = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_mode_e;
endpackage

// File: rtl/ptr_cnt_slice.sv
module ptr_cnt_slice #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         down_i,
  output logic [W-1:0] val_o,
  output logic         chain_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  logic [W-1:0] val_q;
  logic         adv;

  assign adv     = step_i & ~load_i;
  assign chain_o = adv & (down_i ? (val_q == '0) : (val_q == MaxVal));
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= load_val_i;
    else if (step_i) val_q <= down_i ? val_q - 1'b1 : val_q + 1'b1;
  end

  // R3
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> val_q == $past(load_val_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(val_q));

  // R4
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !down_i) |=> val_q == $past(val_q) + 1'b1);

  // R5
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && down_i) |=> val_q == $past(val_q) - 1'b1);

  // R6
  chain_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |=> (val_q == '0 || val_q == MaxVal));
endmodule

// File: rtl/ptr_cnt_readout.sv
module ptr_cnt_readout #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic [N*W-1:0] word_i,
  input  logic           rd_en_i,
  input  logic [N-1:0]   zero_slice_i,
  output logic [N*W-1:0] data_o
);
  for (genvar g = 0; g < N; g++) begin : g_mask
    assign data_o[g*W +: W] = (rd_en_i && !zero_slice_i[g]) ? word_i[g*W +: W] : '0;
  end
endmodule

// File: rtl/ptr_cnt.sv
module ptr_cnt
  import ptr_cnt_pkg::*;
#(
  parameter int        SLICE_W  = 8,
  parameter int        N_SLICES = 2,
  parameter dir_mode_e DIR_MODE = DIR_EXT,
  localparam int       WORD_W   = SLICE_W * N_SLICES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              cnt_en_i,
  input  logic              dir_down_i,
  input  logic [N_SLICES-1:0] zero_slice_i,
  output logic [WORD_W-1:0] data_o,
  output logic              chain_o
);
  logic              down;
  logic [N_SLICES:0] link;
  logic [WORD_W-1:0] word;

  if (DIR_MODE == DIR_UP) begin : g_up
    logic unused_dir;
    assign unused_dir = dir_down_i;
    assign down = 1'b0;
  end else if (DIR_MODE == DIR_DOWN) begin : g_dn
    logic unused_dir;
    assign unused_dir = dir_down_i;
    assign down = 1'b1;
  end else begin : g_ext
    assign down = dir_down_i;
  end

  assign link[0] = cnt_en_i;

  for (genvar g = 0; g < N_SLICES; g++) begin : g_slice
    ptr_cnt_slice #(.W(SLICE_W)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wr_en_i),
      .load_val_i (data_i[g*SLICE_W +: SLICE_W]),
      .step_i     (link[g]),
      .down_i     (down),
      .val_o      (word[g*SLICE_W +: SLICE_W]),
      .chain_o    (link[g+1])
    );
  end

  assign chain_o = link[N_SLICES];

  ptr_cnt_readout #(.W(SLICE_W), .N(N_SLICES)) u_rd (
    .word_i       (word),
    .rd_en_i      (rd_en_i),
    .zero_slice_i (zero_slice_i),
    .data_o       (data_o)
  );

  // R8
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o |=> (word == '0 || word == '1));

  // R3
  no_chain_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !chain_o);

  // R9
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> data_o == '0);
endmodule

// File: tb/tb_ptr_cnt.sv
module tb_ptr_cnt;
  import ptr_cnt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] data_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0, cnt_en_i = 1'b0, dir_down_i = 1'b0;
  logic [1:0]  zero_slice_i = '0;
  logic [15:0] data_o, data2_o;
  logic        chain_o, chain2_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ptr_cnt dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .cnt_en_i(cnt_en_i), .dir_down_i(dir_down_i),
    .zero_slice_i(zero_slice_i), .data_o(data_o), .chain_o(chain_o));

  ptr_cnt #(.DIR_MODE(DIR_DOWN)) dut2 (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .cnt_en_i(cnt_en_i), .dir_down_i(dir_down_i),
    .zero_slice_i(zero_slice_i), .data_o(data2_o), .chain_o(chain2_o));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en_i = 0; cnt_en_i = 0; rd_en_i = 1;
  endtask

  task automatic load(logic [15:0] v);
    @(negedge clk);
    data_i = v; wr_en_i = 1; cnt_en_i = 0; rd_en_i = 1;
    @(posedge clk); #1;
    wr_en_i = 0;
  endtask

  task automatic step(logic dn, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dir_down_i = dn; cnt_en_i = 1; wr_en_i = 0; rd_en_i = 1;
      @(posedge clk); #1;
    end
    cnt_en_i = 0;
  endtask

  task automatic t_reset();
    #2; check("R1 in reset", data_o, 16'h0000);
    @(negedge clk); rst_ni = 1; rd_en_i = 1;
    @(negedge clk); check("R1 after reset", data_o, 16'h0000);
  endtask

  task automatic t_load();
    load(16'hA5C3); check("R2 load", data_o, 16'hA5C3);
    load(16'h0000); check("R2 load zero", data_o, 16'h0000);
  endtask

  task automatic t_prio();
    load(16'h1234);
    @(negedge clk);
    data_i = 16'h00FF; wr_en_i = 1; cnt_en_i = 1; dir_down_i = 0;
    #1 check("R3 chain low under load", {15'd0, chain_o}, 16'h0000);
    @(posedge clk); #1;
    wr_en_i = 0; cnt_en_i = 0;
    check("R3 load wins", data_o, 16'h00FF);
  endtask

  task automatic t_up_hold();
    load(16'h0010);
    step(1'b0, 3); check("R4 up x3", data_o, 16'h0013);
    idle(); @(posedge clk); #1; check("R4 hold", data_o, 16'h0013);
  endtask

  task automatic t_down();
    load(16'h0010);
    step(1'b1, 2); check("R5 down x2", data_o, 16'h000E);
  endtask

  task automatic t_carry();
    load(16'h00FF);
    step(1'b0, 1); check("R6 carry", data_o, 16'h0100);
    load(16'h12FE);
    step(1'b0, 2); check("R6 carry 2", data_o, 16'h1300);
  endtask

  task automatic t_borrow();
    load(16'h0100);
    step(1'b1, 1); check("R7 borrow", data_o, 16'h00FF);
  endtask

  task automatic t_wrap();
    load(16'hFFFF);
    @(negedge clk); dir_down_i = 0; cnt_en_i = 1;
    #1 check("R8 chain up", {15'd0, chain_o}, 16'h0001);
    @(posedge clk); #1; cnt_en_i = 0;
    check("R8 wrap up", data_o, 16'h0000);
    @(negedge clk); dir_down_i = 1; cnt_en_i = 1;
    #1 check("R8 chain down", {15'd0, chain_o}, 16'h0001);
    @(posedge clk); #1; cnt_en_i = 0;
    check("R8 wrap down", data_o, 16'hFFFF);
    load(16'h7FFF);
    @(negedge clk); dir_down_i = 0; cnt_en_i = 1;
    #1 check("R8 no chain mid", {15'd0, chain_o}, 16'h0000);
    @(posedge clk); #1; cnt_en_i = 0;
  endtask

  task automatic t_read();
    load(16'hBEEF);
    @(negedge clk); rd_en_i = 0; #1 check("R9 no read", data_o, 16'h0000);
    rd_en_i = 1; #1 check("R9 read", data_o, 16'hBEEF);
  endtask

  task automatic t_zero();
    load(16'h12FF);
    @(negedge clk); zero_slice_i = 2'b10; #1 check("R10 upper zero", data_o, 16'h00FF);
    step(1'b0, 1); check("R10 masked after carry", data_o, 16'h0000);
    @(negedge clk); zero_slice_i = 2'b00; #1 check("R10 unmasked", data_o, 16'h1300);
    zero_slice_i = 2'b01; #1 check("R10 lower zero", data_o, 16'h1300);
    zero_slice_i = 2'b00;
  endtask

  task automatic t_fixed_dir();
    load(16'h0005);
    step(1'b0, 3);
    check("R11 ext up", data_o, 16'h0008);
    check("R11 fixed down", data2_o, 16'h0002);
    step(1'b1, 1);
    check("R11 fixed down ignores dir", data2_o, 16'h0001);
  endtask

  initial begin
    t_reset();
    t_load();
    t_prio();
    t_up_hold();
    t_down();
    t_carry();
    t_borrow();
    t_wrap();
    t_read();
    t_zero();
    t_fixed_dir();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule